// File: doc/BRIEF.md
# Accumulator Clamp Unit

This unit narrows wide multiply-accumulate results to 16-bit lane values. Every lane holds a 48-bit accumulator seen as three 16-bit slices: the high slice occupies bits 47:32, the middle slice bits 31:16 and the low slice bits 15:0. The high slice and the top bit of the middle slice together decide whether the value fits.

A value that does not fit is clamped to the bound on the side of its sign. A value that fits passes through as one of its slices. A mode input selects signed bounds (0x8000 and 0x7FFF) or unsigned bounds (0x0000 and 0xFFFF). A slice select chooses which slice passes through. Fractional and high-part accumulate forms normally use signed mode with the middle slice. Low-part and normalizing forms use unsigned mode with the low slice.

Eight lanes share one mode and one slice select, so one result vector can be produced every cycle. A parameter either places a register on the output, together with a valid flag, or leaves the path combinational.

Top module: `acc_clamp_vec`

## Requirements
- R1: In signed mode (mode_unsigned = 0), when the high slice is negative and not 0xFFFF, the lane result is 0x8000.
- R2: In signed mode, when the high slice is 0xFFFF and bit 15 of the middle slice is 0, the lane result is 0x8000.
- R3: In signed mode, when the high slice is non-negative and either it is non-zero or bit 15 of the middle slice is 1, the lane result is 0x7FFF.
- R4: In unsigned mode (mode_unsigned = 1), the conditions of R1 and R2 give 0x0000 and the conditions of R3 give 0xFFFF.
- R5: A value is in range when the high slice is 0xFFFF with middle bit 15 set, or the high slice is 0x0000 with middle bit 15 clear. For an in-range value, in either mode, slice_sel = 0 passes the low slice and slice_sel = 1 passes the middle slice.
- R6: For an in-range value with slice_sel = 2 or 3, signed mode passes the middle slice. Unsigned mode passes the middle slice when the high slice is 0x0000 and gives 0x0000 when the high slice is 0xFFFF.
- R7: Lane i reads acc_in[48*i +: 48] and drives res_out[16*i +: 16]. Lanes are independent, and all of them use the same mode and slice select.
- R8: With OUT_REG = 1, out_valid and res_out show the effect of in_valid, mode_unsigned, slice_sel and acc_in sampled at one rising clock edge just after that edge. out_valid is 0 in every cycle whose in_valid was 0.
- R9: While reset is asserted and until the first input is accepted, out_valid is 0 and res_out is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input vector is valid this cycle |
| mode_unsigned | input | 1 | 0 selects signed bounds, 1 selects unsigned bounds |
| slice_sel | input | 2 | 0 selects the low slice, 1 the middle slice, 2 and 3 per R6 |
| acc_in | input | LANES*48 | Packed lane accumulators, lane 0 in the lowest bits |
| out_valid | output | 1 | Result vector is valid |
| res_out | output | LANES*16 | Packed 16-bit lane results |

## Verification
The assertions assume that mode_unsigned, slice_sel and acc_in carry meaning only in cycles where in_valid is 1. They check results only for vectors that were accepted as valid. They also assume that the reset is released away from the clock edge, so the delayed copies of the inputs inside the checker start out empty together with the design's register.

The stimulus drives inputs on the falling edge only and returns in_valid to 0 during gaps. Its high slices are drawn mostly from the boundary values 0x0000, 0xFFFF, 0x0001 and 0xFFFE, so every clamp branch and both in-range branches occur often in both modes and with all four slice selects.

// File: rtl/acc_clamp_pkg.sv
package acc_clamp_pkg;
   // outcome of the range test on one accumulator
   typedef enum logic [1:0] {
      CLS_SAT_NEG  = 2'd0,
      CLS_SAT_POS  = 2'd1,
      CLS_PASS_NEG = 2'd2,
      CLS_PASS_POS = 2'd3
   } clamp_class_e;

   localparam logic [1:0] SEL_LOW = 2'd0;
   localparam logic [1:0] SEL_MID = 2'd1;
endpackage

// File: rtl/acc_clamp_classify.sv
module acc_clamp_classify
   import acc_clamp_pkg::*;
#(
   parameter int SLICE_W = 16
) (
   input  logic [SLICE_W-1:0] hi_slice,
   input  logic [SLICE_W-1:0] mid_slice,
   output clamp_class_e       cls
);
   localparam logic [SLICE_W-1:0] ALL_ONES  = {SLICE_W{1'b1}};
   localparam logic [SLICE_W-1:0] ALL_ZEROS = {SLICE_W{1'b0}};

   logic hi_neg;
   logic mid_top;

   assign hi_neg  = hi_slice[SLICE_W-1];
   assign mid_top = mid_slice[SLICE_W-1];

   always_comb begin
      if (hi_neg) begin
         if (hi_slice != ALL_ONES || !mid_top) cls = CLS_SAT_NEG;
         else                                  cls = CLS_PASS_NEG;
      end else begin
         if (hi_slice != ALL_ZEROS || mid_top) cls = CLS_SAT_POS;
         else                                  cls = CLS_PASS_POS;
      end
   end
endmodule

// File: rtl/acc_clamp_lane.sv
module acc_clamp_lane
   import acc_clamp_pkg::*;
#(
   parameter int SLICE_W = 16
) (
   input  logic [3*SLICE_W-1:0] acc,
   input  logic                 is_unsigned,
   input  logic [1:0]           sel,
   output logic [SLICE_W-1:0]   res
);
   localparam logic [SLICE_W-1:0] S_MIN = {1'b1, {(SLICE_W-1){1'b0}}};
   localparam logic [SLICE_W-1:0] S_MAX = {1'b0, {(SLICE_W-1){1'b1}}};
   localparam logic [SLICE_W-1:0] U_MIN = {SLICE_W{1'b0}};
   localparam logic [SLICE_W-1:0] U_MAX = {SLICE_W{1'b1}};

   logic [SLICE_W-1:0] hi_s, mid_s, lo_s;
   logic [SLICE_W-1:0] neg_bound, pos_bound, pass_val;
   clamp_class_e       cls;

   assign hi_s  = acc[3*SLICE_W-1:2*SLICE_W];
   assign mid_s = acc[2*SLICE_W-1:SLICE_W];
   assign lo_s  = acc[SLICE_W-1:0];

   acc_clamp_classify #(.SLICE_W(SLICE_W)) u_cls (
      .hi_slice (hi_s),
      .mid_slice(mid_s),
      .cls      (cls)
   );

   assign neg_bound = is_unsigned ? U_MIN : S_MIN;
   assign pos_bound = is_unsigned ? U_MAX : S_MAX;

   always_comb begin
      if (sel == SEL_LOW)      pass_val = lo_s;
      else if (sel == SEL_MID) pass_val = mid_s;
      // reserved selects: middle slice, except unsigned negative pass gives zero
      else if (is_unsigned && cls == CLS_PASS_NEG) pass_val = U_MIN;
      else                     pass_val = mid_s;
   end

   always_comb begin
      unique case (cls)
         CLS_SAT_NEG: res = neg_bound;
         CLS_SAT_POS: res = pos_bound;
         default:     res = pass_val;
      endcase
   end
endmodule

// File: rtl/acc_clamp_stage.sv
module acc_clamp_stage #(
   parameter int W      = 16,
   parameter bit OUT_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         d_valid,
   input  logic [W-1:0] d_data,
   output logic         q_valid,
   output logic [W-1:0] q_data
);
   generate
      if (OUT_EN) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q_valid <= 1'b0;
               q_data  <= '0;
            end else begin
               q_valid <= d_valid;
               if (d_valid) q_data <= d_data;
            end
         end
      end else begin : g_wire
         assign q_valid = d_valid;
         assign q_data  = d_data;
      end
   endgenerate
endmodule

// File: rtl/acc_clamp_vec.sv
module acc_clamp_vec #(
   parameter int LANES   = 8,
   parameter int SLICE_W = 16,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic                       mode_unsigned,
   input  logic [1:0]                 slice_sel,
   input  logic [LANES*3*SLICE_W-1:0] acc_in,
   output logic                       out_valid,
   output logic [LANES*SLICE_W-1:0]   res_out
);
   localparam int ACC_W = 3 * SLICE_W;
   localparam int RES_W = LANES * SLICE_W;

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("acc_clamp_vec: LANES must be at least 1");
      end
      if (SLICE_W < 2) begin : g_bad_slice
         $error("acc_clamp_vec: SLICE_W must be at least 2");
      end
   endgenerate

   logic [RES_W-1:0] lane_res;

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         acc_clamp_lane #(.SLICE_W(SLICE_W)) u_lane (
            .acc        (acc_in[l*ACC_W +: ACC_W]),
            .is_unsigned(mode_unsigned),
            .sel        (slice_sel),
            .res        (lane_res[l*SLICE_W +: SLICE_W])
         );
      end
   endgenerate

   acc_clamp_stage #(.W(RES_W), .OUT_EN(OUT_REG)) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_valid(in_valid),
      .d_data (lane_res),
      .q_valid(out_valid),
      .q_data (res_out)
   );
endmodule

// File: rtl/acc_clamp_vec_chk.sv
module acc_clamp_vec_chk #(
   parameter int LANES   = 8,
   parameter int SLICE_W = 16,
   parameter bit OUT_REG = 1'b1
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       in_valid,
   input logic                       mode_unsigned,
   input logic [1:0]                 slice_sel,
   input logic [LANES*3*SLICE_W-1:0] acc_in,
   input logic                       out_valid,
   input logic [LANES*SLICE_W-1:0]   res_out
);
   localparam int S     = SLICE_W;
   localparam int ACC_W = 3 * SLICE_W;
   localparam logic [S-1:0] ONES  = {S{1'b1}};
   localparam logic [S-1:0] ZEROS = {S{1'b0}};
   localparam logic [S-1:0] SMIN  = {1'b1, {(S-1){1'b0}}};
   localparam logic [S-1:0] SMAX  = {1'b0, {(S-1){1'b1}}};

   // inputs aligned to the cycle in which their result is visible
   logic                     a_valid;
   logic                     a_uns;
   logic [1:0]               a_sel;
   logic [LANES*ACC_W-1:0]   a_acc;

   generate
      if (OUT_REG) begin : g_dly
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               a_valid <= 1'b0;
               a_uns   <= 1'b0;
               a_sel   <= 2'd0;
               a_acc   <= '0;
            end else begin
               a_valid <= in_valid;
               a_uns   <= mode_unsigned;
               a_sel   <= slice_sel;
               a_acc   <= acc_in;
            end
         end
      end else begin : g_now
         assign a_valid = in_valid;
         assign a_uns   = mode_unsigned;
         assign a_sel   = slice_sel;
         assign a_acc   = acc_in;
      end
   endgenerate

   p_valid_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == a_valid);

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
         logic [S-1:0] h, m, lo, r;
         assign h  = a_acc[l*ACC_W + 2*S +: S];
         assign m  = a_acc[l*ACC_W + S +: S];
         assign lo = a_acc[l*ACC_W +: S];
         assign r  = res_out[l*S +: S];

         p_neg_sat_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (a_valid && !a_uns && h[S-1] && h != ONES) |-> r == SMIN);
         p_neg_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (a_valid && !a_uns && h == ONES && !m[S-1]) |-> r == SMIN);
         p_pos_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (a_valid && !a_uns && !h[S-1] && (h != ZEROS || m[S-1])) |-> r == SMAX);
         p_uns_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (a_valid && a_uns && h[S-1] && (h != ONES || !m[S-1])) |-> r == ZEROS);
         p_uns_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (a_valid && a_uns && !h[S-1] && (h != ZEROS || m[S-1])) |-> r == ONES);
         p_pass_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (a_valid && a_sel == 2'd0 &&
             ((h == ONES && m[S-1]) || (h == ZEROS && !m[S-1]))) |-> r == lo);
         p_pass_mid_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (a_valid && a_sel == 2'd1 &&
             ((h == ONES && m[S-1]) || (h == ZEROS && !m[S-1]))) |-> r == m);
         p_uns_rsv_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (a_valid && a_uns && a_sel[1] && h == ONES && m[S-1]) |-> r == ZEROS);
         p_sgn_rsv_mid_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (a_valid && !a_uns && a_sel[1] &&
             ((h == ONES && m[S-1]) || (h == ZEROS && !m[S-1]))) |-> r == m);
      end
   endgenerate
endmodule

bind acc_clamp_vec acc_clamp_vec_chk #(
   .LANES(LANES), .SLICE_W(SLICE_W), .OUT_REG(OUT_REG)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .mode_unsigned(mode_unsigned),
   .slice_sel    (slice_sel),
   .acc_in       (acc_in),
   .out_valid    (out_valid),
   .res_out      (res_out)
);

// File: tb/sim_acc_clamp_vec.sv
`timescale 1ns/1ps
module sim_acc_clamp_vec;
   localparam int LANES = 8;
   localparam int S     = 16;
   localparam int A     = 48;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 in_valid = 1'b0;
   logic                 mode_unsigned = 1'b0;
   logic [1:0]           slice_sel = 2'd0;
   logic [LANES*A-1:0]   acc_in = '0;
   logic                 out_valid;
   logic [LANES*S-1:0]   res_out;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [LANES*S-1:0] exp_q[$];
   logic [LANES*4-1:0] tag_q[$];

   always #2.5 clk = ~clk;

   acc_clamp_vec #(.LANES(LANES), .SLICE_W(S), .OUT_REG(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .mode_unsigned(mode_unsigned), .slice_sel(slice_sel),
      .acc_in(acc_in), .out_valid(out_valid), .res_out(res_out)
   );

   // reference from the requirements: treat hi:mid as a signed 32-bit number
   function automatic logic [15:0] model(input logic [47:0] a, input logic uns,
                                         input logic [1:0] sel, output int tag);
      longint v;
      v = longint'($signed(a[47:16]));
      if (v < -32768) begin
         tag = uns ? 4 : ((a[47:32] == 16'hFFFF) ? 2 : 1);   // R1 R2 R4
         return uns ? 16'h0000 : 16'h8000;
      end else if (v > 32767) begin
         tag = uns ? 4 : 3;                                 // R3 R4
         return uns ? 16'hFFFF : 16'h7FFF;
      end else if (sel == 2'd0) begin
         tag = 5;                                           // R5
         return a[15:0];
      end else if (sel == 2'd1) begin
         tag = 5;
         return a[31:16];
      end else begin
         tag = 6;                                           // R6
         return (uns && v < 0) ? 16'h0000 : a[31:16];
      end
   endfunction

   task automatic check(input bit ok, input string req, input logic [127:0] act,
                        input logic [127:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // driver: one vector per call, expected result queued for the monitor
   task automatic send(input logic [LANES*A-1:0] v, input logic uns, input logic [1:0] sel);
      logic [LANES*S-1:0] e;
      logic [LANES*4-1:0] t;
      int tg;
      @(negedge clk);
      in_valid      = 1'b1;
      mode_unsigned = uns;
      slice_sel     = sel;
      acc_in        = v;
      for (int l = 0; l < LANES; l++) begin
         e[l*S +: S] = model(v[l*A +: A], uns, sel, tg);
         t[l*4 +: 4] = 4'(tg);
      end
      exp_q.push_back(e);
      tag_q.push_back(t);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         acc_in   = {LANES*A{1'b1}};
         slice_sel = 2'd3;
      end
      // R8: no result while nothing was accepted
      @(negedge clk);
      check(out_valid == 1'b0 && exp_q.size() == 0, "R8 idle valid",
            128'(out_valid), 128'(0));
   endtask

   // monitor: compares each produced vector lane by lane (R7 placement)
   always @(negedge clk) begin
      if (rst_n && out_valid && !done) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R8 unexpected valid", 128'(1), 128'(0));
         end else begin
            logic [LANES*S-1:0] e;
            logic [LANES*4-1:0] t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            for (int l = 0; l < LANES; l++) begin
               n_checks++;
               if (res_out[l*S +: S] !== e[l*S +: S]) begin
                  n_fail++;
                  $display("FAIL R%0d (R7 lane %0d) actual=%h expected=%h",
                           t[l*4 +: 4], l, res_out[l*S +: S], e[l*S +: S]);
               end
            end
         end
      end
   end

   function automatic logic [47:0] pat(input int k);
      case (k % 8)
         0: return {16'h8000, 16'h1111, 16'h2222};   // R1
         1: return {16'hFFFE, 16'hFFFF, 16'h3333};   // R1 near edge
         2: return {16'hFFFF, 16'h0000, 16'h4444};   // R2
         3: return {16'hFFFF, 16'h7FFF, 16'h5555};   // R2
         4: return {16'h0000, 16'h8000, 16'h6666};   // R3
         5: return {16'h7FFF, 16'h0000, 16'h7777};   // R3
         6: return {16'hFFFF, 16'h8001, 16'h1234};   // in range, negative
         default: return {16'h0000, 16'h7ABC, 16'hABCD}; // in range, positive
      endcase
   endfunction

   function automatic logic [47:0] rnd_acc();
      logic [15:0] h;
      case ($urandom % 5)
         0: h = 16'h0000;
         1: h = 16'hFFFF;
         2: h = 16'h0001;
         3: h = 16'hFFFE;
         default: h = 16'($urandom);
      endcase
      return {h, 16'($urandom), 16'($urandom)};
   endfunction

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      logic [LANES*A-1:0] v;
      repeat (3) @(negedge clk);
      // R9: reset state
      check(out_valid == 1'b0 && res_out == '0, "R9 in reset",
            128'(res_out), 128'(0));
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0 && res_out == '0, "R9 after release",
            128'(res_out), 128'(0));

      // directed classes, both modes, every slice select (R1..R6)
      for (int m = 0; m < 2; m++)
         for (int s = 0; s < 4; s++) begin
            for (int l = 0; l < LANES; l++) v[l*A +: A] = pat(l);
            send(v, m[0], s[1:0]);
         end
      idle(2);

      // R7: rotated lane placement, issued with gaps between vectors (R8)
      for (int r = 1; r < LANES; r++) begin
         for (int l = 0; l < LANES; l++) v[l*A +: A] = pat(l + r);
         send(v, r[0], r[1:0]);
         if (r % 3 == 0) idle(1);
      end
      idle(2);

      // random back-to-back stream
      for (int i = 0; i < 200; i++) begin
         for (int l = 0; l < LANES; l++) v[l*A +: A] = rnd_acc();
         send(v, 1'($urandom), 2'($urandom));
      end
      idle(3);

      // every queued vector must have been produced (R8)
      check(exp_q.size() == 0, "R8 drained", 128'(exp_q.size()), 128'(0));

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule